// File: doc/BRIEF.md
# Word-to-Byte Unpacker

This block splits wide words into bytes for a byte-wide FIFO write port. It runs on a fast clock that is an edge-aligned integer multiple of a slower clock, with both clocks taken from the same PLL. A single-cycle enable, `slow_ce_i`, marks the fast cycle that follows each slow edge. The slow-domain logic presents a 24-bit word with a load request. The unpacker then writes three bytes on three consecutive fast cycles and spends one padding cycle. That fills the four fast cycles of a slow period, so the next word can start in step with the next slow edge. No clock-domain-crossing logic is needed.

All registers use the rising edge of the fast clock. Slow-domain timing enters only through the enable. A parameter selects a second start mode. In that mode the request input is treated as a level, such as the inverted empty flag of a word FIFO, and unpacking starts whenever it is high and continues back to back while it stays high.

Top module: `word_unpacker`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after it is released, `busy_o` and `wr_o` are 0 and `byte_o` is 0x00.
- R2: In the default mode, when the block is idle and `load_req_i` and `slow_ce_i` are both high at a rising edge, the block accepts the word. `wr_o` and `busy_o` are high in the following cycle.
- R3: The bytes of an accepted word appear on `byte_o` in three consecutive cycles, most significant first: bits 23:16, then bits 15:8, then bits 7:0.
- R4: `wr_o` is high for exactly three consecutive cycles per word. These are followed by one padding cycle with `wr_o` low and `busy_o` high.
- R5: The word is captured in the cycle it is accepted. Changes on `word_i` after that cycle do not change the bytes written for that word.
- R6: In the default mode, when the block is idle, a high `load_req_i` with `slow_ce_i` low is ignored, and `busy_o` stays low.
- R7: If a start condition holds at the rising edge that ends the padding cycle, the next word's first byte is written in the next cycle, with no idle cycle between.
- R8: If no start condition holds at the end of the padding cycle, the block returns to idle, and `busy_o` falls in the next cycle.
- R9: In level-start mode (`LEVEL_START=1`), a high `load_req_i` starts unpacking from idle whatever the value of `slow_ce_i`. Words then follow each other with no idle cycles while it stays high.
- R10: `byte_o` is 0x00 in every cycle in which `wr_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, rising edge only |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_ce_i | input | 1 | High for the fast cycle after each slow-clock edge |
| load_req_i | input | 1 | Load request from the slow domain, or a not-empty level in level-start mode |
| word_i | input | 24 | Word to unpack |
| byte_o | output | 8 | Byte for the FIFO write port |
| wr_o | output | 1 | FIFO write strobe, one cycle per byte |
| busy_o | output | 1 | High while bytes or the padding cycle are in progress |

## Verification
The assertions check several rules on every cycle. A start condition in idle must lead to a write in the next cycle, and idle without one must stay idle. Each run of write strobes must be exactly three cycles long and be followed by a busy padding cycle. `busy_o` may not fall straight after a write, and `byte_o` must be zero when no write is made. Byte order and value, and the capture of the word at acceptance, need a known word and a changing input. Only the bench scenarios can show these. The same holds for back-to-back starts held over several slow periods and the level-start variant running beside the default one.

// File: rtl/wu_pkg.sv
package wu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_PAD  = 2'd2
  } wu_phase_e;
endpackage

// File: rtl/wu_accept.sv
module wu_accept
  import wu_pkg::*;
#(
  parameter bit LEVEL_START = 1'b0
) (
  input  wu_phase_e phase_i,
  input  logic      pad_end_i,
  input  logic      slow_ce_i,
  input  logic      load_req_i,
  output logic      go_o
);
  logic start_ok;
  logic slot_free;

  generate
    if (LEVEL_START) begin : g_level
      assign start_ok = load_req_i;
    end else begin : g_edge
      assign start_ok = load_req_i & slow_ce_i;
    end
  endgenerate

  assign slot_free = (phase_i == ST_IDLE) | pad_end_i;
  assign go_o      = start_ok & slot_free;
endmodule

// File: rtl/wu_fsm.sv
module wu_fsm
  import wu_pkg::*;
#(
  parameter int BYTES   = 3,
  parameter int PAD_CYC = 1,
  parameter int LANE_W  = 2,
  parameter int PAD_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  output wu_phase_e         phase_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              pad_end_o
);
  wu_phase_e         phase_q;
  logic [LANE_W-1:0] lane_q;
  logic [PAD_W-1:0]  pad_q;
  logic              last_lane;
  logic              pad_end;

  assign last_lane = (lane_q == LANE_W'(BYTES - 1));
  assign pad_end   = (phase_q == ST_PAD) && (pad_q == PAD_W'(PAD_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_IDLE;
      lane_q  <= '0;
      pad_q   <= '0;
    end else begin
      unique case (phase_q)
        ST_IDLE: begin
          if (go_i) begin
            phase_q <= ST_EMIT;
            lane_q  <= '0;
          end
        end
        ST_EMIT: begin
          if (last_lane) begin
            phase_q <= ST_PAD;
            pad_q   <= '0;
          end else begin
            lane_q <= lane_q + 1'b1;
          end
        end
        ST_PAD: begin
          if (pad_end) begin
            phase_q <= go_i ? ST_EMIT : ST_IDLE;
            lane_q  <= '0;
          end else begin
            pad_q <= pad_q + 1'b1;
          end
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign lane_o    = lane_q;
  assign pad_end_o = pad_end;
endmodule

// File: rtl/wu_hold.sv
module wu_hold #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 3,
  parameter int LANE_W = 2,
  parameter int WORD_W = BYTE_W * BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              emit_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [WORD_W-1:0] word_q;
  logic [BYTE_W-1:0] lanes [BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  // lane 0 is the most significant byte
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign lanes[k] = word_q[WORD_W-1-k*BYTE_W -: BYTE_W];
  end

  always_comb begin
    byte_o = '0;
    if (emit_i) begin
      for (int k = 0; k < BYTES; k++) begin
        if (lane_i == LANE_W'(k)) byte_o = lanes[k];
      end
    end
  end
endmodule

// File: rtl/word_unpacker.sv
module word_unpacker
  import wu_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int BYTES       = 3,
  parameter int RATIO       = 4,
  parameter bit LEVEL_START = 1'b0,
  localparam int WORD_W     = BYTE_W * BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_ce_i,
  input  logic              load_req_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              wr_o,
  output logic              busy_o
);
  localparam int PAD_CYC = RATIO - BYTES;
  localparam int LANE_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int PAD_W   = (PAD_CYC > 1) ? $clog2(PAD_CYC) : 1;

  wu_phase_e         phase;
  logic [LANE_W-1:0] lane;
  logic              pad_end;
  logic              go;
  logic              emit;

  wu_accept #(.LEVEL_START(LEVEL_START)) u_accept (
    .phase_i   (phase),
    .pad_end_i (pad_end),
    .slow_ce_i (slow_ce_i),
    .load_req_i(load_req_i),
    .go_o      (go)
  );

  wu_fsm #(
    .BYTES  (BYTES),
    .PAD_CYC(PAD_CYC),
    .LANE_W (LANE_W),
    .PAD_W  (PAD_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .phase_o  (phase),
    .lane_o   (lane),
    .pad_end_o(pad_end)
  );

  assign emit = (phase == ST_EMIT);

  wu_hold #(
    .BYTE_W(BYTE_W),
    .BYTES (BYTES),
    .LANE_W(LANE_W)
  ) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(go),
    .word_i(word_i),
    .emit_i(emit),
    .lane_i(lane),
    .byte_o(byte_o)
  );

  assign wr_o   = emit;
  assign busy_o = (phase != ST_IDLE);
endmodule

// File: rtl/wu_checker.sv
module wu_checker #(
  parameter int BYTE_W      = 8,
  parameter int BYTES       = 3,
  parameter bit LEVEL_START = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slow_ce_i,
  input logic              load_req_i,
  input logic [BYTE_W-1:0] byte_o,
  input logic              wr_o,
  input logic              busy_o
);
  localparam int RUN_W = $clog2(BYTES + 1) + 1;

  logic [RUN_W-1:0] run_q;
  logic             start_ok;

  assign start_ok = load_req_i & (LEVEL_START | slow_ce_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (wr_o) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_ok) |=> (wr_o && busy_o));

  a_r6_stay_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_ok) |=> !busy_o);

  a_r4_run_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (run_q < RUN_W'(BYTES)));

  a_r4_run_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_o) |-> (run_q == RUN_W'(BYTES) && busy_o));

  a_r8_idle_after_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(wr_o));

  a_r10_quiet_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_o |-> (byte_o == '0));
endmodule

bind word_unpacker wu_checker #(
  .BYTE_W     (BYTE_W),
  .BYTES      (BYTES),
  .LEVEL_START(LEVEL_START)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .slow_ce_i (slow_ce_i),
  .load_req_i(load_req_i),
  .byte_o    (byte_o),
  .wr_o      (wr_o),
  .busy_o    (busy_o)
);

// File: tb/word_unpacker_tb.sv
`timescale 1ns/1ps
module word_unpacker_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slow_ce = 1'b0;
  logic        load_req = 1'b0;
  logic [23:0] word = '0;
  logic [7:0]  byte_e, byte_l;
  logic        wr_e, wr_l, busy_e, busy_l;

  int vectors = 0;
  int miscompares = 0;
  int phase = 0;
  int m_pos [2];
  logic [23:0] m_w [2];
  bit done = 1'b0;

  always #2 clk = ~clk;

  word_unpacker u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .slow_ce_i(slow_ce), .load_req_i(load_req),
    .word_i(word), .byte_o(byte_e), .wr_o(wr_e), .busy_o(busy_e)
  );

  word_unpacker #(.LEVEL_START(1'b1)) u_dut_lvl (
    .clk_i(clk), .rst_ni(rst_ni), .slow_ce_i(slow_ce), .load_req_i(load_req),
    .word_i(word), .byte_o(byte_l), .wr_o(wr_l), .busy_o(busy_l)
  );

  function automatic logic [7:0] exp_byte(input int pos, input logic [23:0] w);
    if (pos < 1 || pos > 3) return 8'h00;
    return 8'((w >> (8 * (3 - pos))) & 24'hFF);
  endfunction

  task automatic check(input int d, input string tag);
    logic [7:0] ab, eb;
    logic aw, ew, ay, ey;
    ab = (d == 0) ? byte_e : byte_l;
    aw = (d == 0) ? wr_e : wr_l;
    ay = (d == 0) ? busy_e : busy_l;
    eb = exp_byte(m_pos[d], m_w[d]);
    ew = (m_pos[d] >= 1 && m_pos[d] <= 3);
    ey = (m_pos[d] != 0);
    vectors++;
    if (ab !== eb || aw !== ew || ay !== ey) begin
      miscompares++;
      $display("FAIL %s dut%0d: wr=%0b byte=%h busy=%0b, expected wr=%0b byte=%h busy=%0b",
               tag, d, aw, ab, ay, ew, eb, ey);
    end
  endtask

  task automatic step(input bit req, input logic [23:0] w, input string tag);
    bit ce;
    ce = (phase == 0);
    load_req = req;
    word = w;
    slow_ce = ce;
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      bit go;
      go = (m_pos[d] == 0 || m_pos[d] == 4) && req && (d == 1 || ce);
      if (go) begin
        m_pos[d] = 1;
        m_w[d] = w;
      end else if (m_pos[d] >= 1 && m_pos[d] <= 3) m_pos[d] = m_pos[d] + 1;
      else m_pos[d] = 0;
    end
    phase = (phase + 1) % 4;
    @(negedge clk);
    check(0, tag);
    check(1, tag);
  endtask

  task automatic align(input string tag);
    while (phase != 0) step(1'b0, 24'h0, tag);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_pos[0] = 0; m_pos[1] = 0;
    m_w[0] = '0;  m_w[1] = '0;
    repeat (3) @(negedge clk);
    check(0, "R1");
    check(1, "R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check(0, "R1");
    check(1, "R1");
    phase = 0;

    // request off the enable cycle: default ignores, level mode starts
    step(1'b0, 24'h0, "R1");
    for (int i = 0; i < 3; i++) step(1'b1, 24'h0F1E2D, "R6 R9");
    for (int i = 0; i < 8; i++) step(1'b0, 24'h0, "R8");

    // single word, input disturbed during unpacking
    align("R8");
    step(1'b1, 24'hA5C3E1, "R2");
    step(1'b0, 24'h123456, "R3 R5");
    step(1'b0, 24'h654321, "R3 R5");
    step(1'b0, 24'hFFFFFF, "R3 R5");
    step(1'b0, 24'h000000, "R4");
    step(1'b0, 24'h000000, "R8");
    step(1'b0, 24'h000000, "R10");

    // request held over several slow periods
    align("R8");
    for (int i = 0; i < 16; i++) step(1'b1, 24'h10_20_30 + 24'(i * 24'h010101), "R7 R9");
    for (int i = 0; i < 6; i++) step(1'b0, 24'h0, "R8");

    // random traffic, dense and sparse
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, 24'($urandom), "R3 R4");
    for (int i = 0; i < 3000; i++)
      step(($urandom % 5) == 0, 24'($urandom), "R7 R8 R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule